// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through FIFO Chain

This block builds one deep FIFO out of a row of identical first-word-fall-through buffer stages, joined in series with no logic between them. Each stage raises an active-low "word available" flag and an active-low "space available" flag. A stage's word-available flag is wired directly to the write enable of the stage after it. That stage's space-available flag is wired directly back to the read enable of the stage before it. The whole chain runs on one transfer clock. Externally the chain behaves as a single FIFO whose capacity is the number of stages times the per-stage depth.

A word written into an empty chain moves down to the far end without any read request. Each stage shows a newly written word on its output three cycles after it accepts it. Each stage reports a freed location on its space flag two cycles after a word leaves it. Because of this, the first word crosses the chain in (N−1)·4+3 cycles. A location freed at the far end of a full chain reaches the entry in (N−1)·3+2 cycles. Once the chain is running, words stream at one per cycle.

A master reset is asserted asynchronously and released synchronously inside the block. A synchronous partial clear empties every stage.

Top module: `fwft_cascade`

## Requirements
- R1: While the chain holds no accepted, unread word, including after master reset or partial clear, `in_ready_n` is 0 and `out_ready_n` is 1.
- R2: Words leave in the order they were accepted. With no reads, exactly NSTAGES×STAGE_DEPTH writes are accepted.
- R3: A write with `wr_n` = 0 is accepted only at an edge where `in_ready_n` is 0. Any other write leaves the contents unchanged, and no extra word ever appears at the output.
- R4: A read with `rd_n` = 0 is accepted only at an edge where `out_ready_n` is 0. A read attempted while the chain is empty has no effect on later data or latency.
- R5: Suppose one word is written into an empty chain at edge E and no read is issued. Then `out_ready_n` first reads 0 after edge E+(NSTAGES−1)·4+3.
- R6: Suppose a full, settled chain is read once at edge E. Then `in_ready_n` first reads 0 after edge E+(NSTAGES−1)·3+2.
- R7: With the default stage depth of 8, consider a burst written one word per cycle into an empty chain, with a read issued whenever `out_ready_n` is 0. No write is refused, and the words come out on consecutive cycles with no gap.
- R8: When `part_rst_n` is 0 at an edge, after that edge `out_ready_n` is 1 and `in_ready_n` is 0. Every stored word is discarded, including words still moving between stages.
- R9: While `out_ready_n` is 0, `rd_data` is the oldest unread word. It stays unchanged, with `out_ready_n` held at 0, until it is read or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock shared by all stages |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| part_rst_n | input | 1 | Synchronous partial clear, active low |
| wr_n | input | 1 | Write request, active low |
| wr_data | input | WIDTH | Word to write |
| in_ready_n | output | 1 | First stage has a free location, active low |
| rd_n | input | 1 | Read request, active low |
| rd_data | output | WIDTH | Oldest word, valid while `out_ready_n` is 0 |
| out_ready_n | output | 1 | Last stage holds a word, active low |

## Verification
In every stage a push and a pop can land in the same cycle. So the stage's write-side count may be raised by a new word and lowered by a delayed free report at one edge, and its read-side count may be raised by a delayed arrival and lowered by a read at that same edge. The streaming test provokes this continuously. It writes a word every cycle while reading whenever the far end reports data, so every stage pushes and pops together for many cycles. The result is judged by three things: no write is refused, the data sequence comes out intact, and output words arrive on consecutive cycles starting exactly at the fall-through latency. The same collision at the chain edges is also seen in the fill-then-drain sweep, which is run for both two and three stages.

// File: rtl/fwft_cascade_pkg.sv
package fwft_cascade_pkg;
  // cycles from an accepted push to the word becoming visible on the read side
  localparam int unsigned FILL_DELAY = 3;
  // cycles from an accepted pop to the location becoming visible on the write side
  localparam int unsigned FREE_DELAY = 2;
endpackage

// File: rtl/fwft_pulse_line.sv
module fwft_pulse_line #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] line_q;
  logic [STAGES-1:0] line_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb line_d = clr ? 1'b0 : din;
    end else begin : g_multi
      always_comb line_d = clr ? '0 : {line_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign dout = line_q[STAGES-1];
endmodule

// File: rtl/fwft_stage.sv
module fwft_stage
  import fwft_cascade_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             in_ready_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_ready_n
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    wcnt_q, wcnt_d;   // occupancy as the write side sees it
  logic [CW-1:0]    rcnt_q, rcnt_d;   // occupancy as the read side sees it
  logic             push, pop, push_seen, pop_seen;

  assign in_ready_n  = (wcnt_q == CNT_FULL);
  assign out_ready_n = (rcnt_q == '0);
  assign push        = ~wr_en_n & ~in_ready_n;
  assign pop         = ~rd_en_n & ~out_ready_n;
  assign rd_data     = mem[rptr_q];

  fwft_pulse_line #(.STAGES(FILL_DELAY)) u_fill_line (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .din  (push),
    .dout (push_seen)
  );

  fwft_pulse_line #(.STAGES(FREE_DELAY)) u_free_line (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .din  (pop),
    .dout (pop_seen)
  );

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    wcnt_d = wcnt_q;
    rcnt_d = rcnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      wcnt_d = '0;
      rcnt_d = '0;
    end else begin
      if (push) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + AW'(1);
      if (pop)  rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + AW'(1);
      wcnt_d = wcnt_q + CW'(push) - CW'(pop_seen);
      rcnt_d = rcnt_q + CW'(push_seen) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      wcnt_q <= wcnt_d;
      rcnt_q <= rcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wr_data;
  end
endmodule

// File: rtl/fwft_cascade.sv
module fwft_cascade #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned STAGE_DEPTH = 8,
  parameter int unsigned NSTAGES     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             part_rst_n,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             in_ready_n,
  input  logic             rd_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_ready_n
);
  logic [1:0]         rst_pipe_q;
  logic               rst_int;
  logic               clr;
  logic [NSTAGES-1:0] st_in_n, st_out_n, st_wr_n, st_rd_n;
  logic [WIDTH-1:0]   st_d [NSTAGES];
  logic [WIDTH-1:0]   st_q [NSTAGES];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int = rst_pipe_q[1];
  assign clr     = ~part_rst_n;

  generate
    for (genvar k = 0; k < NSTAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
        assign st_wr_n[k] = wr_n;
        assign st_d[k]    = wr_data;
      end else begin : g_link_in
        assign st_wr_n[k] = st_out_n[k-1];
        assign st_d[k]    = st_q[k-1];
      end
      if (k == NSTAGES - 1) begin : g_tail
        assign st_rd_n[k] = rd_n;
      end else begin : g_link_out
        assign st_rd_n[k] = st_in_n[k+1];
      end

      fwft_stage #(.WIDTH(WIDTH), .DEPTH(STAGE_DEPTH)) u_stage (
        .clk        (clk),
        .rst_n      (rst_int),
        .clr        (clr),
        .wr_en_n    (st_wr_n[k]),
        .wr_data    (st_d[k]),
        .in_ready_n (st_in_n[k]),
        .rd_en_n    (st_rd_n[k]),
        .rd_data    (st_q[k]),
        .out_ready_n(st_out_n[k])
      );
    end
  endgenerate

  assign in_ready_n  = st_in_n[0];
  assign out_ready_n = st_out_n[NSTAGES-1];
  assign rd_data     = st_q[NSTAGES-1];
endmodule

// File: rtl/fwft_cascade_chk.sv
module fwft_cascade_chk #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned STAGE_DEPTH = 8,
  parameter int unsigned NSTAGES     = 2
) (
  input logic             clk,
  input logic             rst_int,
  input logic             part_rst_n,
  input logic             wr_n,
  input logic             in_ready_n,
  input logic             rd_n,
  input logic             out_ready_n,
  input logic [WIDTH-1:0] rd_data
);
  localparam int unsigned CAP = NSTAGES * STAGE_DEPTH;
  localparam int unsigned OW  = $clog2(CAP + 1);

  logic [OW-1:0] occ_q;

  // port-level count of accepted and not yet read words
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)         occ_q <= '0;
    else if (!part_rst_n) occ_q <= '0;
    else                  occ_q <= occ_q + OW'(~wr_n & ~in_ready_n) - OW'(~rd_n & ~out_ready_n);
  end

  p_empty_flags_r1: assert property (@(posedge clk) disable iff (!rst_int)
    (occ_q == '0) |-> (out_ready_n && !in_ready_n));

  p_capacity_r2: assert property (@(posedge clk) disable iff (!rst_int)
    occ_q <= OW'(CAP));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_int)
    (occ_q == OW'(CAP)) |-> in_ready_n);

  p_pclear_r8: assert property (@(posedge clk) disable iff (!rst_int)
    !part_rst_n |=> (out_ready_n && !in_ready_n));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_int)
    (!out_ready_n && rd_n && part_rst_n) |=> (!out_ready_n && $stable(rd_data)));
endmodule

bind fwft_cascade fwft_cascade_chk #(
  .WIDTH(WIDTH), .STAGE_DEPTH(STAGE_DEPTH), .NSTAGES(NSTAGES)
) u_chk (
  .clk        (clk),
  .rst_int    (rst_int),
  .part_rst_n (part_rst_n),
  .wr_n       (wr_n),
  .in_ready_n (in_ready_n),
  .rd_n       (rd_n),
  .out_ready_n(out_ready_n),
  .rd_data    (rd_data)
);

// File: tb/fwft_cascade_bench.sv
module fwft_cascade_bench;
  localparam int W = 16;
  localparam int D = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         prst_n [2];
  logic         wr_n   [2];
  logic [W-1:0] wd     [2];
  logic         rd_n   [2];
  logic         in_n   [2];
  logic         out_n  [2];
  logic [W-1:0] rdd    [2];

  int checks = 0;
  int errors = 0;

  fwft_cascade #(.WIDTH(W), .STAGE_DEPTH(D), .NSTAGES(2)) u_fwft_cascade (
    .clk(clk), .rst_n(rst_n), .part_rst_n(prst_n[0]), .wr_n(wr_n[0]), .wr_data(wd[0]),
    .in_ready_n(in_n[0]), .rd_n(rd_n[0]), .rd_data(rdd[0]), .out_ready_n(out_n[0]));

  fwft_cascade #(.WIDTH(W), .STAGE_DEPTH(D), .NSTAGES(3)) u_fwft_cascade_n3 (
    .clk(clk), .rst_n(rst_n), .part_rst_n(prst_n[1]), .wr_n(wr_n[1]), .wr_data(wd[1]),
    .in_ready_n(in_n[1]), .rd_n(rd_n[1]), .rd_data(rdd[1]), .out_ready_n(out_n[1]));

  function automatic int nst(input int idx);
    return (idx == 0) ? 2 : 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int idx, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s N=%0d actual=%0d expected=%0d", req, nst(idx), act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // write one word, measure cycles to the first output-ready, check its value
  task automatic fall_through(input int idx, input logic [W-1:0] val, input string req);
    int lat;
    int exp_lat;
    exp_lat = (nst(idx) - 1) * 4 + 3;
    wd[idx] = val; wr_n[idx] = 1'b0;
    @(negedge clk); wr_n[idx] = 1'b1;
    lat = -1;
    for (int k = 1; k <= 60 && lat < 0; k++) begin
      @(negedge clk);
      if (!out_n[idx]) lat = k;
    end
    chk(lat == exp_lat, {req, " fall-through latency"}, idx, lat, exp_lat);
    chk(rdd[idx] == val, "R9 head word value", idx, rdd[idx], val);
  endtask

  task automatic read_one(input int idx);
    rd_n[idx] = 1'b0;
    @(negedge clk); rd_n[idx] = 1'b1;
  endtask

  task automatic run_tests(input int idx);
    int cap;
    int nxt;
    int got;
    int first;
    int gaps;
    int stalls;
    int lat;
    bit held;
    bit quiet;
    cap = nst(idx) * D;

    // R5 and R9: single word into empty chain, held without read
    fall_through(idx, 16'hA5C3, "R5");
    held = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (out_n[idx] || rdd[idx] != 16'hA5C3) held = 1'b0;
    end
    chk(held, "R9 word held until read", idx, held, 1);
    read_one(idx);
    chk(out_n[idx] == 1'b1, "R1 empty after last read", idx, out_n[idx], 1);
    chk(in_n[idx] == 1'b0, "R1 space after last read", idx, in_n[idx], 0);

    // R4: reads while empty are ignored
    rd_n[idx] = 1'b0;
    quiet = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!out_n[idx]) quiet = 1'b0;
    end
    rd_n[idx] = 1'b1;
    chk(quiet, "R4 empty read shows no data", idx, quiet, 1);
    fall_through(idx, 16'h3C5A, "R4");
    read_one(idx);

    // R2, R3: fill with writes held low well past capacity
    nxt = 0;
    for (int t = 0; t < cap + 40; t++) begin
      wd[idx] = W'(16'h1000 + nxt);
      wr_n[idx] = 1'b0;
      if (!in_n[idx]) nxt++;
      @(negedge clk);
    end
    wr_n[idx] = 1'b1;
    chk(nxt == cap, "R2 accepted write count", idx, nxt, cap);
    repeat (20) @(negedge clk);
    chk(in_n[idx] == 1'b1, "R3 full chain refuses", idx, in_n[idx], 1);

    // R6: one read from full, bubble to the entry
    chk(rdd[idx] == 16'h1000, "R2 first word order", idx, rdd[idx], 16'h1000);
    read_one(idx);
    lat = -1;
    for (int k = 1; k <= 60 && lat < 0; k++) begin
      if (in_n[idx] == 1'b0) lat = k - 1;
      if (lat < 0) @(negedge clk);
    end
    chk(lat == (nst(idx) - 1) * 3 + 2, "R6 free-space latency", idx, lat, (nst(idx) - 1) * 3 + 2);

    // drain and check order
    got = 1;
    for (int t = 0; t < 400 && got < cap; t++) begin
      if (!out_n[idx]) begin
        chk(rdd[idx] == W'(16'h1000 + got), "R2 drain order", idx, rdd[idx], 16'h1000 + got);
        rd_n[idx] = 1'b0;
        got++;
      end else begin
        rd_n[idx] = 1'b1;
      end
      @(negedge clk);
    end
    rd_n[idx] = 1'b1;
    chk(got == cap, "R2 drained word count", idx, got, cap);
    repeat (20) @(negedge clk);
    chk(out_n[idx] == 1'b1, "R3 no refused word appears", idx, out_n[idx], 1);

    // R7: streaming with simultaneous write and read every cycle
    nxt = 0; got = 0; first = -1; gaps = 0; stalls = 0;
    rd_n[idx] = 1'b0;
    for (int cyc = 0; cyc < 400 && got < 40; cyc++) begin
      if (nxt < 40) begin
        wd[idx] = W'(16'h2000 + nxt);
        wr_n[idx] = 1'b0;
        if (!in_n[idx]) nxt++;
        else stalls++;
      end else begin
        wr_n[idx] = 1'b1;
      end
      if (!out_n[idx]) begin
        if (first < 0) first = cyc;
        if (cyc != first + got) gaps++;
        chk(rdd[idx] == W'(16'h2000 + got), "R7 stream data order", idx, rdd[idx], 16'h2000 + got);
        got++;
      end
      @(negedge clk);
    end
    wr_n[idx] = 1'b1; rd_n[idx] = 1'b1;
    chk(stalls == 0, "R7 no refused write", idx, stalls, 0);
    chk(gaps == 0, "R7 no output gap", idx, gaps, 0);
    chk(got == 40, "R7 words streamed", idx, got, 40);
    chk(first == (nst(idx) - 1) * 4 + 4, "R5 stream first word cycle", idx, first, (nst(idx) - 1) * 4 + 4);

    // R8: partial clear with settled words
    for (int k = 0; k < 5; k++) begin
      wd[idx] = W'(16'h3000 + k); wr_n[idx] = 1'b0;
      @(negedge clk);
    end
    wr_n[idx] = 1'b1;
    repeat (30) @(negedge clk);
    prst_n[idx] = 1'b0;
    @(negedge clk); prst_n[idx] = 1'b1;
    chk(out_n[idx] == 1'b1, "R8 output flag after clear", idx, out_n[idx], 1);
    chk(in_n[idx] == 1'b0, "R8 input flag after clear", idx, in_n[idx], 0);
    // R8: clear while a word is still in flight
    wd[idx] = 16'h3EEE; wr_n[idx] = 1'b0;
    @(negedge clk); wr_n[idx] = 1'b1; prst_n[idx] = 1'b0;
    @(negedge clk); prst_n[idx] = 1'b1;
    quiet = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (!out_n[idx]) quiet = 1'b0;
    end
    chk(quiet, "R8 in-flight word discarded", idx, quiet, 1);
    fall_through(idx, 16'h4D2B, "R8");
    read_one(idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 2; i++) begin
      prst_n[i] = 1'b1; wr_n[i] = 1'b1; rd_n[i] = 1'b1; wd[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(out_n[i] == 1'b1, "R1 reset output flag", i, out_n[i], 1);
      chk(in_n[i] == 1'b0, "R1 reset input flag", i, in_n[i], 0);
    end
    for (int i = 0; i < 2; i++) run_tests(i);
    summary();
    $finish;
  end
endmodule